// File: doc/BRIEF.md
# Byte Fetch from Word-Wide Program Memory

This block serves the load-from-program-memory operations of a small processor core. Program memory is 16 bits wide and addressed by word, while the pointer register pair that names the location holds a byte address. The block turns that byte address into a word address plus a half select, reads the word, picks the right byte and writes it to the register file.

An operation is requested with a one-cycle start strobe, a form code and a destination index. There are three forms. The implied form always writes register 0. The explicit form writes the named register. The post-increment form writes the named register and then advances the pointer by one. Every operation takes exactly three cycles after it is accepted. In the first cycle the word address goes to the memory. In the second cycle the read data comes back. In the third cycle the register write, any pointer update and the completion pulse all happen. No condition flags are touched.

Top module: `pmem_byte_fetch`

## Requirements
- R1: After reset, busy_o, done_o, pm_en_o, rf_we_o and ptr_we_o are all low.
- R2: The form code is 2'b00 for the implied form, 2'b01 for the explicit form and 2'b10 for the post-increment form. The implied form writes register index 0, whatever value dest_i holds.
- R3: The explicit and post-increment forms write the register index that was on dest_i when the start was accepted.
- R4: In the first cycle after acceptance, pm_en_o is high and pm_addr_o equals the captured pointer shifted right by one bit.
- R5: An even pointer value returns bits 7:0 of the word, and an odd pointer value returns bits 15:8. For example, the word 16'h5876 gives 8'h76 at the even address and 8'h58 at the odd address.
- R6: rf_we_o and done_o are high for exactly one cycle, the third cycle after acceptance. busy_o is high for cycles one to three.
- R7: Only the post-increment form raises ptr_we_o. It does so in the third cycle, with ptr_wdata_o equal to the captured pointer plus one.
- R8: Post-incrementing the pointer from 16'hFFFF writes 16'h0000.
- R9: A start while busy_o is high is ignored. It does not change the address, the destination, the data or the pointer of the operation in progress.
- R10: A start with the reserved form code 2'b11 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| form_i | input | 2 | Operation form code |
| dest_i | input | 5 | Destination register index |
| ptr_i | input | 16 | Current pointer (byte address) |
| ptr_we_o | output | 1 | Pointer update strobe |
| ptr_wdata_o | output | 16 | New pointer value |
| pm_en_o | output | 1 | Program memory read enable |
| pm_addr_o | output | 15 | Program memory word address |
| pm_rdata_i | input | 16 | Program memory read data, one cycle after enable |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 5 | Register file write index |
| rf_wdata_o | output | 8 | Register file write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions assume that program memory answers exactly one cycle after pm_en_o with the word at pm_addr_o. They also assume that ptr_i is valid in the cycle a start is accepted, and they compare the selected byte against the read data seen in the second cycle. The bench's memory model is a registered read with that single-cycle latency. It computes each word from its address, so every pointer the sweep drives has a known expected byte. Starts that should be ignored are issued only while an operation is in flight or with the reserved code. The bench then confirms that the operation in flight completes with its own values.

// File: rtl/pmem_byte_fetch.sv
module pmem_byte_fetch #(
  parameter int PTR_W = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       form_i,
  input  logic [IDX_W-1:0] dest_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             ptr_we_o,
  output logic [PTR_W-1:0] ptr_wdata_o,
  output logic             pm_en_o,
  output logic [PTR_W-2:0] pm_addr_o,
  input  logic [15:0]      pm_rdata_i,
  output logic             rf_we_o,
  output logic [IDX_W-1:0] rf_waddr_o,
  output logic [7:0]       rf_wdata_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [1:0] FORM_IMPL = 2'b00;
  localparam logic [1:0] FORM_POST = 2'b10;
  localparam logic [1:0] FORM_RSVD = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_WRITE} state_t;

  state_t           st;
  logic [PTR_W-1:0] ptr_q;
  logic [IDX_W-1:0] dst_q;
  logic             post_q;
  logic [7:0]       byte_q;
  logic             accept;

  assign accept = start_i && (st == S_IDLE) && (form_i != FORM_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr_q  <= '0;
      dst_q  <= '0;
      post_q <= 1'b0;
      byte_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_ADDR;
          ptr_q  <= ptr_i;
          dst_q  <= (form_i == FORM_IMPL) ? '0 : dest_i;
          post_q <= (form_i == FORM_POST);
        end
        S_ADDR:  st <= S_DATA;
        S_DATA: begin
          st     <= S_WRITE;
          byte_q <= ptr_q[0] ? pm_rdata_i[15:8] : pm_rdata_i[7:0];
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pm_en_o     = (st == S_ADDR);
  assign pm_addr_o   = ptr_q[PTR_W-1:1];
  assign rf_we_o     = (st == S_WRITE);
  assign rf_waddr_o  = dst_q;
  assign rf_wdata_o  = byte_q;
  assign ptr_we_o    = (st == S_WRITE) && post_q;
  assign ptr_wdata_o = ptr_q + 1'b1;
  assign done_o      = (st == S_WRITE);
  assign busy_o      = (st != S_IDLE);

  AST_SEQ_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pm_en_o && !rf_we_o ##1 !pm_en_o && !rf_we_o ##1 rf_we_o && done_o); // R6
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pm_addr_o == $past(ptr_i[PTR_W-1:1])); // R4
  AST_IMPLIED_R0: assert property (@(posedge clk) disable iff (!rst_n)
    accept && form_i == FORM_IMPL |=> ##2 rf_waddr_o == '0); // R2
  AST_BYTE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##2 rf_wdata_o == ($past(ptr_i[0], 3) ? $past(pm_rdata_i[15:8]) : $past(pm_rdata_i[7:0]))); // R5
  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    accept && form_i == FORM_POST |=> ##2 ptr_we_o && ptr_wdata_o == $past(ptr_i, 3) + 1'b1); // R7
  AST_NO_PTR_WE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && form_i != FORM_POST |=> ##2 !ptr_we_o); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> $stable(rf_waddr_o) && $stable(pm_addr_o)); // R9
  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && form_i == FORM_RSVD |=> !busy_o && !pm_en_o); // R10

endmodule

// File: tb/pmem_byte_fetch_bench.sv
module pmem_byte_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  form_i = 2'b00;
  logic [4:0]  dest_i = '0;
  logic [15:0] ptr_i = '0;
  logic        ptr_we_o, pm_en_o, rf_we_o, busy_o, done_o;
  logic [15:0] ptr_wdata_o;
  logic [14:0] pm_addr_o;
  logic [15:0] pm_rdata_i = '0;
  logic [4:0]  rf_waddr_o;
  logic [7:0]  rf_wdata_o;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pmem_byte_fetch u_pmem_byte_fetch (.*);

  function automatic logic [15:0] mem_word(input logic [14:0] a);
    if (a == 15'h0080) return 16'h5876;
    return {a[7:0] ^ 8'hC3, a[14:7] + 8'h11};
  endfunction

  always @(posedge clk) if (pm_en_o) pm_rdata_i <= mem_word(pm_addr_o);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [1:0] f, input logic [4:0] d, input logic [15:0] z, input logic noise);
    logic [15:0] w;
    logic [7:0]  b;
    logic [4:0]  ed;
    w  = mem_word(z[15:1]);
    b  = z[0] ? w[15:8] : w[7:0];
    ed = (f == 2'b00) ? 5'd0 : d;
    @(negedge clk);
    start_i = 1'b1; form_i = f; dest_i = d; ptr_i = z;
    @(negedge clk);
    if (noise) begin form_i = 2'b01; dest_i = ~d; ptr_i = ~z; end
    else start_i = 1'b0;
    chk(pm_en_o && busy_o && !rf_we_o, "R6", {pm_en_o, busy_o, rf_we_o}, 3'b110);
    chk(pm_addr_o == z[15:1], "R4", pm_addr_o, z[15:1]);
    @(negedge clk);
    chk(!pm_en_o && !rf_we_o && !done_o && busy_o, "R6", {pm_en_o, rf_we_o, done_o, busy_o}, 4'b0001);
    chk(!noise || pm_addr_o == z[15:1], "R9", pm_addr_o, z[15:1]);
    @(negedge clk);
    start_i = 1'b0;
    chk(rf_we_o && done_o && busy_o, "R6", {rf_we_o, done_o, busy_o}, 3'b111);
    chk(rf_wdata_o == b, "R5", rf_wdata_o, b);
    chk(rf_waddr_o == ed, (f == 2'b00) ? "R2" : "R3", rf_waddr_o, ed);
    chk(ptr_we_o == (f == 2'b10), "R7", ptr_we_o, (f == 2'b10));
    if (f == 2'b10) chk(ptr_wdata_o == z + 16'd1, (z == 16'hFFFF) ? "R8" : "R7", ptr_wdata_o, z + 16'd1);
    @(negedge clk);
    chk(!busy_o && !rf_we_o && !done_o && !ptr_we_o, "R6", {busy_o, rf_we_o, done_o, ptr_we_o}, 0);
  endtask

  initial begin
    #(200000 * 10);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !pm_en_o && !rf_we_o && !ptr_we_o, "R1",
        {busy_o, done_o, pm_en_o, rf_we_o, ptr_we_o}, 0);
    rst_n = 1'b1;
    for (int f = 0; f < 3; f++)
      for (int z = 0; z < 64; z++)
        fetch(f[1:0], 5'(z * 7 + f), 16'(z * 16'h0403 + f), 1'b0);
    fetch(2'b00, 5'd17, 16'h0100, 1'b0);
    fetch(2'b01, 5'd9,  16'h0101, 1'b0);
    fetch(2'b10, 5'd31, 16'hFFFF, 1'b0);
    fetch(2'b10, 5'd3,  16'hFFFE, 1'b0);
    fetch(2'b01, 5'd12, 16'h8001, 1'b1);
    fetch(2'b10, 5'd20, 16'h1234, 1'b1);
    @(negedge clk);
    start_i = 1'b1; form_i = 2'b11; dest_i = 5'd5; ptr_i = 16'h0042;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o && !pm_en_o, "R10", {busy_o, pm_en_o}, 0);
    @(negedge clk);
    chk(!busy_o && !rf_we_o && !done_o, "R10", {busy_o, rf_we_o, done_o}, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule